// File: doc/BRIEF.md
# String Operation Sequencer

This block runs one string primitive, or a repeated run of them, against a byte-wide synchronous memory port. The primitives are copy, load into the accumulator, store from the accumulator, compare two strings, and scan a string for the accumulator value. Each works on bytes or on little-endian 16-bit words. A start pulse latches the operation, the width, the repeat mode, the direction bit, the source pointer, the destination pointer, the count and the accumulator. The block then steps through the memory accesses one byte per cycle. Every address carries a one-bit tag that selects the data segment (source side) or the extra segment (destination side).

A repeat mode tests the count before each iteration and decrements it after each executed primitive. The conditional modes also end the run when the zero flag from the latest comparison leaves the wanted state. When the run ends, the updated pointers, count, accumulator and zero, carry and sign flags sit on the outputs, and a one-cycle done pulse marks completion. The flags keep their value across runs that do not compare.

Top module: `strop_seq`

## Requirements
- R1: A direction bit of 0 advances each pointer that a primitive touches by 1 for a byte or by 2 for a word. A direction bit of 1 moves it back by the same amount.
- R2: Operation code 0 (copy) reads the element at the source pointer in the data segment. It writes the element to the destination pointer in the extra segment and steps both pointers.
- R3: Operation code 1 (load) reads the element at the source pointer into the accumulator and steps only the source pointer. A byte load keeps the accumulator's upper byte.
- R4: Operation code 2 (store) writes the accumulator's low byte, or the whole word, to the destination pointer in the extra segment. It steps only the destination pointer.
- R5: Operation code 3 (compare) computes source element minus destination element at the selected width and writes no memory. ZF is set when the difference is zero, CF when the subtraction borrows, and SF from the difference's top bit. Both pointers step.
- R6: Operation code 4 (scan) computes the destination element minus the accumulator, with flags as in R5. It steps only the destination pointer.
- R7: The repeat field is 0 for none, 1 for unconditional, 2 for while-equal and 3 for while-not-equal. With any repeat mode and a count of zero, the run ends with no memory access, and the pointers, count, accumulator and flags are unchanged.
- R8: Unconditional repeat runs the primitive exactly count times and leaves the count at zero.
- R9: With a compare or scan, while-equal stops after an iteration that leaves ZF=0, and while-not-equal stops after one that leaves ZF=1. Both stop when the count reaches zero, and each executed iteration lowers the count by one.
- R10: With no repeat mode, the primitive runs exactly once and the count is unchanged.
- R11: A word takes two byte accesses, with the low byte at the pointer and the high byte at pointer+1. The segment tag is 0 for the data segment and 1 for the extra segment. Read data returns in the cycle after the request, and no cycle both reads and writes.
- R12: Busy is high from the cycle after the accepted start until the done cycle. Done is high for exactly one cycle. A start that arrives while busy is ignored.
- R13: One iteration takes 1 check cycle plus a body of 2n+1 cycles for copy, n+2 for load, n+1 for store, 2n+2 for compare and n+2 for scan, where n is the byte count. A zero-count repeat takes one check cycle. Done follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| op_sel | input | 3 | Primitive: 0 copy, 1 load, 2 store, 3 compare, 4 scan |
| wide | input | 1 | 1 selects 16-bit elements |
| rep_sel | input | 2 | Repeat mode |
| dir | input | 1 | Direction: 0 up, 1 down |
| src_in | input | AW | Initial source pointer |
| dst_in | input | AW | Initial destination pointer |
| cnt_in | input | AW | Initial repeat count |
| acc_in | input | 16 | Initial accumulator |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write request |
| mem_seg | output | 1 | Segment tag: 0 data, 1 extra |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| cnt | output | AW | Current count |
| acc_out | output | 16 | Accumulator |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry (borrow) flag |
| sf | output | 1 | Sign flag |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench's model counts the cycles a run needs from the per-iteration formula of R13. On every falling edge after the start edge, it compares busy and done with that count, so done must appear exactly in cycle T+1 and nowhere else. The pointers, count, accumulator and flags are sampled in the cycle after done, when they are final. Both segment memories are compared against the model's copies at that point. Read data is answered by the bench memory on the edge after each request, which matches the one-cycle return the design expects.

// File: rtl/strop_seq.sv
module strop_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_sel,
  input  logic          wide,
  input  logic [1:0]    rep_sel,
  input  logic          dir,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [AW-1:0] cnt_in,
  input  logic [15:0]   acc_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_seg,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [AW-1:0] cnt,
  output logic [15:0]   acc_out,
  output logic          zf,
  output logic          cf,
  output logic          sf,
  output logic          busy,
  output logic          done
);

  localparam logic [2:0] OP_MOVE  = 3'd0;
  localparam logic [2:0] OP_LOAD  = 3'd1;
  localparam logic [2:0] OP_STORE = 3'd2;
  localparam logic [2:0] OP_CMP   = 3'd3;
  localparam logic [2:0] OP_SCAN  = 3'd4;
  localparam logic [1:0] RP_NONE  = 2'd0;
  localparam logic [1:0] RP_EQ    = 2'd2;
  localparam logic [1:0] RP_NE    = 2'd3;
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_RA, S_RB, S_WR, S_WAIT, S_UPD, S_DONE
  } st_t;

  st_t           st_q;
  logic [2:0]    op_q;
  logic [1:0]    rep_q;
  logic          wid_q, dir_q, k_q;
  logic [AW-1:0] src_q, dst_q, cnt_q;
  logic [15:0]   acc_q, buf_a, buf_b;
  logic          zf_q, cf_q, sf_q;
  logic          cap_v, cap_b, cap_k;

  logic          last_k, is_cmp, fwd, stop;
  logic [AW-1:0] step, src_nxt, dst_nxt, cnt_nxt, kofs;
  logic [15:0]   opb;
  logic [16:0]   diff;
  logic          zf_n, cf_n, sf_n;
  logic [7:0]    wbyte;

  assign last_k  = (k_q == wid_q);
  assign is_cmp  = (op_q == OP_CMP) || (op_q == OP_SCAN);
  assign step    = wid_q ? STEP_W : STEP_B;
  assign src_nxt = dir_q ? src_q - step : src_q + step;
  assign dst_nxt = dir_q ? dst_q - step : dst_q + step;
  assign cnt_nxt = (rep_q != RP_NONE) ? cnt_q - STEP_B : cnt_q;
  assign kofs    = {{(AW-1){1'b0}}, k_q};

  assign opb  = (op_q == OP_SCAN) ? acc_q : buf_b;
  assign diff = wid_q ? ({1'b0, buf_a} - {1'b0, opb})
                      : {8'd0, ({1'b0, buf_a[7:0]} - {1'b0, opb[7:0]})};
  assign zf_n = wid_q ? (diff[15:0] == 16'd0) : (diff[7:0] == 8'd0);
  assign cf_n = wid_q ? diff[16] : diff[8];
  assign sf_n = wid_q ? diff[15] : diff[7];

  assign stop = (rep_q == RP_NONE) || (cnt_nxt == '0) ||
                (is_cmp && rep_q == RP_EQ && !zf_n) ||
                (is_cmp && rep_q == RP_NE && zf_n);

  assign fwd   = cap_v && !cap_b && (cap_k == k_q);
  assign wbyte = (op_q == OP_MOVE)
                 ? (fwd ? mem_rdata : (k_q ? buf_a[15:8] : buf_a[7:0]))
                 : (k_q ? acc_q[15:8] : acc_q[7:0]);

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_seg   = 1'b0;
    mem_addr  = '0;
    mem_wdata = 8'd0;
    case (st_q)
      S_RA: begin
        mem_rd   = 1'b1;
        mem_seg  = (op_q == OP_SCAN);
        mem_addr = ((op_q == OP_SCAN) ? dst_q : src_q) + kofs;
      end
      S_RB: begin
        mem_rd   = 1'b1;
        mem_seg  = 1'b1;
        mem_addr = dst_q + kofs;
      end
      S_WR: begin
        mem_wr    = 1'b1;
        mem_seg   = 1'b1;
        mem_addr  = dst_q + kofs;
        mem_wdata = wbyte;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v <= 1'b0;
      cap_b <= 1'b0;
      cap_k <= 1'b0;
      buf_a <= '0;
      buf_b <= '0;
    end else begin
      cap_v <= (st_q == S_RA) || (st_q == S_RB);
      cap_b <= (st_q == S_RB);
      cap_k <= k_q;
      if (cap_v) begin
        if (cap_b) begin
          if (cap_k) buf_b[15:8] <= mem_rdata; else buf_b[7:0] <= mem_rdata;
        end else begin
          if (cap_k) buf_a[15:8] <= mem_rdata; else buf_a[7:0] <= mem_rdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      op_q  <= '0;
      rep_q <= '0;
      wid_q <= 1'b0;
      dir_q <= 1'b0;
      k_q   <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      acc_q <= '0;
      zf_q  <= 1'b0;
      cf_q  <= 1'b0;
      sf_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          op_q  <= op_sel;
          rep_q <= rep_sel;
          wid_q <= wide;
          dir_q <= dir;
          src_q <= src_in;
          dst_q <= dst_in;
          cnt_q <= cnt_in;
          acc_q <= acc_in;
          st_q  <= S_CHK;
        end
        S_CHK: begin
          k_q <= 1'b0;
          if (rep_q != RP_NONE && cnt_q == '0) st_q <= S_DONE;
          else begin
            case (op_q)
              OP_MOVE, OP_LOAD, OP_CMP, OP_SCAN: st_q <= S_RA;
              OP_STORE:                          st_q <= S_WR;
              default:                           st_q <= S_DONE;
            endcase
          end
        end
        S_RA: begin
          if (last_k) begin
            k_q  <= 1'b0;
            st_q <= (op_q == OP_MOVE) ? S_WR : (op_q == OP_CMP) ? S_RB : S_WAIT;
          end else k_q <= 1'b1;
        end
        S_RB: begin
          if (last_k) begin
            k_q  <= 1'b0;
            st_q <= S_WAIT;
          end else k_q <= 1'b1;
        end
        S_WR: begin
          if (last_k) begin
            k_q  <= 1'b0;
            st_q <= S_UPD;
          end else k_q <= 1'b1;
        end
        S_WAIT: st_q <= S_UPD;
        S_UPD: begin
          if (op_q == OP_MOVE || op_q == OP_LOAD || op_q == OP_CMP) src_q <= src_nxt;
          if (op_q != OP_LOAD) dst_q <= dst_nxt;
          cnt_q <= cnt_nxt;
          if (op_q == OP_LOAD) acc_q <= wid_q ? buf_a : {acc_q[15:8], buf_a[7:0]};
          if (is_cmp) begin
            zf_q <= zf_n;
            cf_q <= cf_n;
            sf_q <= sf_n;
          end
          st_q <= stop ? S_DONE : S_CHK;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign src_ptr = src_q;
  assign dst_ptr = dst_q;
  assign cnt     = cnt_q;
  assign acc_out = acc_q;
  assign zf      = zf_q;
  assign cf      = cf_q;
  assign sf      = sf_q;
  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_DONE);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R11
  AST_WR_EXTRA_SEG: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> mem_seg); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R12
  AST_NOREP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rep_q == RP_NONE) |=> $stable(cnt)); // R10
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_UPD && !dir_q) |=> ((src_ptr - $past(src_ptr)) <= STEP_W)); // R1
  AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_UPD && dir_q) |=> (($past(dst_ptr) - dst_ptr) <= STEP_W)); // R1

endmodule

// File: tb/strop_seq_tb_top.sv
module strop_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        wide = 1'b0;
  logic [1:0]  rep_sel = '0;
  logic        dir = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0, acc_in = '0;
  logic        mem_rd, mem_wr, mem_seg;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] src_ptr, dst_ptr, cnt, acc_out;
  logic        zf, cf, sf, busy, done;

  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  strop_seq #(.AW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .wide(wide),
    .rep_sel(rep_sel), .dir(dir), .src_in(src_in), .dst_in(dst_in),
    .cnt_in(cnt_in), .acc_in(acc_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_seg(mem_seg), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt(cnt),
    .acc_out(acc_out), .zf(zf), .cf(cf), .sf(sf), .busy(busy), .done(done)
  );

  function automatic logic [7:0] ds0(int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [7:0] es0(int i);
    if (i >= 'h40 && i < 'h48 && i != 'h44) return ds0(i);
    return 8'(i) ^ 8'hA5;
  endfunction

  logic [7:0] dsm [256];
  logic [7:0] esm [256];
  logic [7:0] rds [256];
  logic [7:0] res [256];
  logic rzf = 0, rcf = 0, rsf = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        dsm[i] <= ds0(i);
        esm[i] <= es0(i);
      end
    end else begin
      if (mem_rd) mem_rdata <= mem_seg ? esm[mem_addr[7:0]] : dsm[mem_addr[7:0]];
      if (mem_wr) begin
        if (mem_seg) esm[mem_addr[7:0]] <= mem_wdata;
        else dsm[mem_addr[7:0]] <= mem_wdata;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rget(bit seg, logic [15:0] a, bit w);
    logic [7:0] lo, hi;
    lo = seg ? res[a[7:0]] : rds[a[7:0]];
    hi = seg ? res[8'(a[7:0] + 8'd1)] : rds[8'(a[7:0] + 8'd1)];
    return w ? {hi, lo} : {8'd0, lo};
  endfunction

  task automatic rput(logic [15:0] a, logic [15:0] v, bit w);
    res[a[7:0]] = v[7:0];
    if (w) res[8'(a[7:0] + 8'd1)] = v[15:8];
  endtask

  task automatic run(string req, logic [2:0] o, bit w, logic [1:0] r, bit d,
                     logic [15:0] s, logic [15:0] t, logic [15:0] c,
                     logic [15:0] a, bit poke);
    int nb = w ? 2 : 1;
    int tot = 0;
    int k, badk;
    bit go = 1;
    logic [15:0] ms = s, mt = t, mc = c, ma = a, va, vb, st;
    logic [16:0] df;
    bit is_cmp = (o == 3'd3 || o == 3'd4);
    st = d ? 16'(-nb) : 16'(nb);
    while (go) begin
      if (r != 2'd0 && mc == 16'd0) begin
        tot += 1;
        break;
      end
      case (o)
        3'd0: begin rput(mt, rget(0, ms, w), w); ms += st; mt += st; tot += 1 + 2*nb + 1; end
        3'd1: begin va = rget(0, ms, w); ma = w ? va : {ma[15:8], va[7:0]}; ms += st; tot += 1 + nb + 2; end
        3'd2: begin rput(mt, ma, w); mt += st; tot += 1 + nb + 1; end
        3'd3: begin va = rget(0, ms, w); vb = rget(1, mt, w); ms += st; mt += st; tot += 1 + 2*nb + 2; end
        default: begin va = rget(1, mt, w); vb = w ? ma : {8'd0, ma[7:0]}; mt += st; tot += 1 + nb + 2; end
      endcase
      if (is_cmp) begin
        df = {1'b0, va} - {1'b0, vb};
        rzf = w ? (df[15:0] == 0) : (df[7:0] == 0);
        rcf = w ? df[16] : (va[7:0] < vb[7:0]);
        rsf = w ? df[15] : df[7];
      end
      if (r == 2'd0) go = 0;
      else begin
        mc -= 16'd1;
        if (mc == 0) go = 0;
        if (is_cmp && r == 2'd2 && !rzf) go = 0;
        if (is_cmp && r == 2'd3 && rzf) go = 0;
      end
    end

    @(negedge clk);
    op_sel = o; wide = w; rep_sel = r; dir = d;
    src_in = s; dst_in = t; cnt_in = c; acc_in = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1; badk = 0;
    while (1) begin
      if (busy !== 1'b1 || done !== (k == tot + 1)) begin
        if (badk == 0) badk = k;
      end
      if (poke && k == 1) begin
        start = 1'b1; op_sel = 3'd2; cnt_in = 16'd9; src_in = 16'h00EE; dst_in = 16'h00EE;
      end
      if (poke && k == 2) start = 1'b0;
      if (done === 1'b1 || k > tot + 20) break;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    @(negedge clk);
    if ((busy !== 1'b0 || done !== 1'b0) && badk == 0) badk = k + 1;
    chk({req, " R13 R12"}, "first off-schedule cycle (0 = none)", badk, 0);
    chk(req, "src pointer", src_ptr, ms);
    chk(req, "dst pointer", dst_ptr, mt);
    chk(req, "count", cnt, mc);
    chk(req, "accumulator", acc_out, ma);
    chk(req, "flags zf,cf,sf", {zf, cf, sf}, {rzf, rcf, rsf});
    begin
      int mism = 0;
      for (int i = 0; i < 256; i++)
        if (dsm[i] !== rds[i] || esm[i] !== res[i]) mism++;
      chk({req, " R11"}, "memory bytes differing", mism, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      rds[i] = ds0(i);
      res[i] = es0(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset busy/done", {busy, done}, 0);
    chk("R12", "reset mem requests", {mem_rd, mem_wr}, 0);
    chk("R12", "reset pointers/count", {src_ptr, dst_ptr}, 0);
    chk("R12", "reset acc/flags", {acc_out, zf, cf, sf}, 0);

    run("R2 R10 R1",      3'd0, 0, 2'd0, 0, 16'h0010, 16'h0080, 16'd5, 16'h0000, 0);
    run("R2 R8 R1 R11",   3'd0, 1, 2'd1, 1, 16'h0020, 16'h0090, 16'd3, 16'h0000, 0);
    run("R3 R10",         3'd1, 0, 2'd0, 0, 16'h0030, 16'h0000, 16'd7, 16'hBEEF, 0);
    run("R3 R8",          3'd1, 1, 2'd1, 0, 16'h0030, 16'h0000, 16'd2, 16'h0000, 0);
    run("R4 R8",          3'd2, 1, 2'd1, 0, 16'h0000, 16'h00A0, 16'd3, 16'h1234, 0);
    run("R4 R1 R12",      3'd2, 0, 2'd1, 1, 16'h0000, 16'h00B0, 16'd2, 16'h0077, 1);
    run("R5 R10",         3'd3, 0, 2'd0, 0, 16'h0000, 16'h0000, 16'd4, 16'h0000, 0);
    run("R5 R9",          3'd3, 1, 2'd2, 0, 16'h0040, 16'h0040, 16'd4, 16'h0000, 0);
    run("R6 R9",          3'd4, 0, 2'd3, 0, 16'h0000, 16'h0060, 16'd8, 16'h00C6, 0);
    run("R6 R10",         3'd4, 0, 2'd0, 0, 16'h0000, 16'h0050, 16'd1, 16'h00F6, 0);
    run("R7",             3'd0, 1, 2'd1, 0, 16'h0070, 16'h00C0, 16'd0, 16'h0000, 0);
    run("R7 R9",          3'd3, 0, 2'd2, 0, 16'h0070, 16'h00C0, 16'd0, 16'h0000, 0);
    run("R9 R1",          3'd3, 0, 2'd3, 1, 16'h0047, 16'h0047, 16'd5, 16'h0000, 0);

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule